// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Sequencer

This block sits between a set of free-running source clocks and the pins that carry them off the die. Each output (CPU, SDRAM, PCI, 3V66, IOAPIC, 48 MHz and REF by default) passes through a gate cell. The cell opens and closes only while its own source is low, so a gated output never carries a shortened pulse. A static per-output enable vector and two group stop inputs decide which outputs run in normal operation.

An active-low, asynchronous power-down request is brought into the sequencer's always-on clock domain before it acts. The sequencer first withdraws the run permission from every gate. Each gate reports back once it has parked low, and that report is synchronised back as well. Only when every output, the slowest one included, confirms it is parked are the VCO and crystal enables removed. When the request is released, the oscillator enables are restored at once. The outputs are allowed to run again only after a programmable settle count has expired and the lock input is high.

The sequencer states are RUN, STOP_OUTPUTS, WAIT_ALL_LOW, OSC_OFF and WAKE. The transitions are:
- RUN → STOP_OUTPUTS when a synchronised request is seen.
- STOP_OUTPUTS → WAIT_ALL_LOW unconditionally after one cycle.
- WAIT_ALL_LOW → OSC_OFF once every gate confirms it is parked.
- OSC_OFF → WAKE when the request is released.
- WAKE → RUN when the settle count is spent and lock is high.
- WAKE → OSC_OFF if the request returns during settling.

Reset enters WAKE.

Top module: `pdn_clkseq`

## Requirements
- R1: `pd_n` passes through a two-flop synchroniser on `clk`. When `pd_n` rises while the sequencer is in OSC_OFF, `vco_en` and `xtal_en` are still low after the second `clk` rising edge and high after the third.
- R2: Every gated output changes only on edges of its own source. Each high pulse of `clk_out[i]` lasts a full high phase of `src_clk[i]`, and `clk_out[i]` is never high while `src_clk[i]` is low.
- R3: `vco_en` and `xtal_en` fall together and never while the outputs run. While they are low, every bit of `clk_out` stays low and does not toggle.
- R4: The oscillator enables are removed only after every gate, including the slowest (REF, index 6), has confirmed it is parked. A REF pulse already under way, or one whose gate has not yet closed, completes before the oscillators stop.
- R5: An output whose `out_en` bit is 0 is held low and does not toggle. Enabled neighbours keep running.
- R6: In RUN, `cpu_stop_n` low holds the outputs selected by `CPU_MASK` (default index 0) low, and `pci_stop_n` low does the same for `PCI_MASK` (default index 2). All other outputs keep running.
- R7: While the oscillators are off, changes on `cpu_stop_n` and `pci_stop_n` have no effect on `vco_en`, `xtal_en` or any output.
- R8: After wake-up, outputs restart no earlier than `SETTLE_CYC` cycles after entry into WAKE, and only while `pll_lock` is high. With lock low, the outputs stay parked indefinitely while the oscillators run.
- R9: A power-down request that returns during WAKE sends the sequencer straight back to OSC_OFF within three cycles, with no output pulse in between.
- R10: Reset leaves the sequencer in WAKE with the oscillator enables high and all outputs low. The outputs then start after the settle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_stop_n | input | 1 | Active-low stop for the CPU output group |
| pci_stop_n | input | 1 | Active-low stop for the PCI output group |
| out_en | input | N_OUT | Per-output enable, 1 = may run |
| src_clk | input | N_OUT | Free-running source clock for each output |
| pll_lock | input | 1 | Lock indication from the synthesiser |
| clk_out | output | N_OUT | Gated clock outputs |
| vco_en | output | 1 | VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The assertions assume three things about the inputs:
- `out_en` and the mask selection do not change while a stop sequence is under way.
- Every source clock keeps toggling until its gate has confirmed it is parked.
- `pll_lock` is a level sampled on `clk`.

The stimulus changes enables and stop inputs only in RUN, with drain time afterwards. It keeps every source running throughout. It places every `pd_n` and `pll_lock` change a quarter period after a `clk` edge, with source half-periods chosen so that no source edge coincides with a sampling point.

// File: rtl/pdn_seq_pkg.sv
`timescale 1ns/1ps
package pdn_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN          = 3'd0,
        ST_STOP_OUTPUTS = 3'd1,
        ST_WAIT_ALL_LOW = 3'd2,
        ST_OSC_OFF      = 3'd3,
        ST_WAKE         = 3'd4
    } seq_state_e;

    localparam int OUT_CPU   = 0;
    localparam int OUT_SDRAM = 1;
    localparam int OUT_PCI   = 2;
    localparam int OUT_V66   = 3;
    localparam int OUT_APIC  = 4;
    localparam int OUT_USB48 = 5;
    localparam int OUT_REF   = 6;
    localparam int NUM_OUTS  = 7;

endpackage

// File: rtl/pdn_bit_sync.sv
`timescale 1ns/1ps
module pdn_bit_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell (
    input  logic src_clk,
    input  logic rst_n,
    input  logic want,
    output logic gclk,
    output logic parked
);
    logic catch_q;
    logic gate_q;

    // capture the run permission on the rising edge of the source
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) catch_q <= 1'b0;
        else        catch_q <= want;
    end

    // move the gate only while the source is low
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= catch_q;
    end

    assign gclk   = src_clk & gate_q;
    assign parked = ~gate_q;
endmodule

// File: rtl/pdn_fsm.sv
`timescale 1ns/1ps
module pdn_fsm
    import pdn_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic all_parked,
    input  logic pll_lock,
    output logic run_en,
    output logic osc_en
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:          if (pd_req) state_d = ST_STOP_OUTPUTS;
            ST_STOP_OUTPUTS: state_d = ST_WAIT_ALL_LOW;
            ST_WAIT_ALL_LOW: if (all_parked) state_d = ST_OSC_OFF;
            ST_OSC_OFF:      if (!pd_req) state_d = ST_WAKE;
            ST_WAKE: begin
                if (pd_req)                         state_d = ST_OSC_OFF;
                else if (cnt_q == LAST && pll_lock) state_d = ST_RUN;
            end
            default:         state_d = ST_WAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAKE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_WAKE) cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        run_en = 1'b0;
        osc_en = 1'b1;
        unique case (state_q)
            ST_RUN:          run_en = 1'b1;
            ST_STOP_OUTPUTS: run_en = 1'b0;
            ST_WAIT_ALL_LOW: run_en = 1'b0;
            ST_OSC_OFF:      osc_en = 1'b0;
            ST_WAKE:         run_en = 1'b0;
            default:         run_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/pdn_clkseq.sv
`timescale 1ns/1ps
module pdn_clkseq
    import pdn_seq_pkg::*;
#(
    parameter int               N_OUT      = NUM_OUTS,
    parameter int               SETTLE_CYC = 64,
    parameter logic [N_OUT-1:0] CPU_MASK   = N_OUT'(1) << OUT_CPU,
    parameter logic [N_OUT-1:0] PCI_MASK   = N_OUT'(1) << OUT_PCI
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic [N_OUT-1:0] out_en,
    input  logic [N_OUT-1:0] src_clk,
    input  logic             pll_lock,
    output logic [N_OUT-1:0] clk_out,
    output logic             vco_en,
    output logic             xtal_en
);
    logic             pd_n_sync;
    logic             run_en;
    logic             osc_en;
    logic [N_OUT-1:0] stop_mask;
    logic [N_OUT-1:0] want_q;
    logic [N_OUT-1:0] parked_raw;
    logic [N_OUT-1:0] parked_sync;

    pdn_bit_sync #(.W(1), .RST_VAL(1'b1)) u_pd_sync (
        .clk(clk), .rst_n(rst_n), .d(pd_n), .q(pd_n_sync)
    );

    pdn_bit_sync #(.W(N_OUT), .RST_VAL({N_OUT{1'b1}})) u_park_sync (
        .clk(clk), .rst_n(rst_n), .d(parked_raw), .q(parked_sync)
    );

    pdn_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_req     (~pd_n_sync),
        .all_parked (&parked_sync),
        .pll_lock   (pll_lock),
        .run_en     (run_en),
        .osc_en     (osc_en)
    );

    assign stop_mask = (cpu_stop_n ? '0 : CPU_MASK) | (pci_stop_n ? '0 : PCI_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) want_q <= '0;
        else        want_q <= run_en ? (out_en & ~stop_mask) : '0;
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        clk_gate_cell u_cell (
            .src_clk (src_clk[g]),
            .rst_n   (rst_n),
            .want    (want_q[g]),
            .gclk    (clk_out[g]),
            .parked  (parked_raw[g])
        );
    end

    assign vco_en  = osc_en;
    assign xtal_en = osc_en;
endmodule

// File: rtl/pdn_clkseq_chk.sv
`timescale 1ns/1ps
module pdn_clkseq_chk #(
    parameter int N_OUT = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             vco_en,
    input logic             xtal_en,
    input logic             pll_lock,
    input logic [N_OUT-1:0] clk_out,
    input logic [N_OUT-1:0] parked_sync
);
    AST_RUN_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> (vco_en && xtal_en)); // R8
    AST_OFF_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !xtal_en |-> (clk_out == '0)); // R3
    AST_OFF_AFTER_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xtal_en) |-> $past(&parked_sync)); // R4
    AST_OFF_NOT_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en) |-> $past(!run_en)); // R3
    AST_RUN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> $past(pll_lock)); // R8
endmodule

bind pdn_clkseq pdn_clkseq_chk #(.N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .vco_en(vco_en),
    .xtal_en(xtal_en), .pll_lock(pll_lock), .clk_out(clk_out),
    .parked_sync(parked_sync)
);

// File: tb/test_pdn_clkseq.sv
`timescale 1ns/1ps
module test_pdn_clkseq;
    localparam int N      = 7;
    localparam int SETTLE = 64;
    localparam int REF    = 6;

    logic clk = 1'b0, rst_n = 1'b0, pd_n = 1'b1;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pll_lock = 1'b1;
    logic [N-1:0] out_en = '1;
    wire  [N-1:0] src;
    logic [N-1:0] clk_out;
    logic vco_en, xtal_en;

    int n_chk = 0, n_fail = 0;
    int tog [N];
    int runt[N];
    realtime t_rise[N];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_src
        localparam real HP = (g == REF) ? 35.3 : 3.1 + 1.2 * g;
        logic s_clk = 1'b0;
        always #(HP) s_clk = ~s_clk;
        assign src[g] = s_clk;
        always @(posedge clk_out[g]) begin
            tog[g]++;
            t_rise[g] = $realtime;
        end
        always @(negedge clk_out[g])
            if (t_rise[g] > 0.0 && ($realtime - t_rise[g]) < HP - 0.01) runt[g]++;
    end

    pdn_clkseq #(.SETTLE_CYC(SETTLE)) i_pdn_clkseq (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cpu_stop_n(cpu_stop_n),
        .pci_stop_n(pci_stop_n), .out_en(out_en), .src_clk(src),
        .pll_lock(pll_lock), .clk_out(clk_out), .vco_en(vco_en), .xtal_en(xtal_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1.25;
    endtask

    task automatic snap(output int s[N]);
        for (int i = 0; i < N; i++) s[i] = tog[i];
    endtask

    function automatic int moved(input int s[N]);
        int m = 0;
        for (int i = 0; i < N; i++) m += tog[i] - s[i];
        return m;
    endfunction

    task automatic wait_off(output int cyc);
        cyc = 0;
        while (xtal_en && cyc < 400) begin tick(1); cyc++; end
    endtask

    task automatic t_reset();
        int s[N];
        tick(5);
        rst_n = 1'b1;
        snap(s);
        tick(1);
        chk(xtal_en && vco_en, "R10", "osc enables after reset", int'(xtal_en), 1);
        chk(clk_out == '0, "R10", "outputs low after reset", int'(clk_out), 0);
        tick(SETTLE - 5);
        chk(moved(s) == 0, "R10", "no toggles during settle", moved(s), 0);
        tick(40);
        for (int i = 0; i < N; i++)
            chk(tog[i] > s[i], "R8", "output runs after settle", tog[i] - s[i], 1);
    endtask

    task automatic t_glitch();
        int bad = 0;
        for (int k = 0; k < 100; k++) begin
            tick(1);
            if ((clk_out & ~src) != '0) bad++;
        end
        chk(bad == 0, "R2", "output high while source low", bad, 0);
    endtask

    task automatic t_enables();
        int s[N];
        out_en[5] = 1'b0;
        tick(20);
        snap(s);
        tick(60);
        chk(tog[5] == s[5] && !clk_out[5], "R5", "disabled output toggles", tog[5] - s[5], 0);
        chk(tog[4] > s[4], "R5", "enabled neighbour runs", tog[4] - s[4], 1);
        out_en[5] = 1'b1;
        tick(20);
        snap(s);
        tick(40);
        chk(tog[5] > s[5], "R5", "re-enabled output runs", tog[5] - s[5], 1);
    endtask

    task automatic t_stops();
        int s[N];
        cpu_stop_n = 1'b0;
        tick(20); snap(s); tick(60);
        chk(tog[0] == s[0], "R6", "cpu group stopped", tog[0] - s[0], 0);
        chk(tog[2] > s[2], "R6", "pci group runs under cpu stop", tog[2] - s[2], 1);
        cpu_stop_n = 1'b1;
        pci_stop_n = 1'b0;
        tick(20); snap(s); tick(60);
        chk(tog[2] == s[2], "R6", "pci group stopped", tog[2] - s[2], 0);
        chk(tog[0] > s[0], "R6", "cpu group runs under pci stop", tog[0] - s[0], 1);
        pci_stop_n = 1'b1;
        tick(20);
    endtask

    task automatic t_powerdown();
        int s[N];
        int ref0, cyc;
        @(posedge clk_out[REF]);
        tick(1);
        pd_n = 1'b0;
        ref0 = tog[REF];
        wait_off(cyc);
        chk(!xtal_en && !vco_en, "R3", "oscillators stopped", int'(xtal_en), 0);
        chk(clk_out == '0, "R3", "outputs low at oscillator stop", int'(clk_out), 0);
        chk(cyc >= 18, "R4", "cycles waited for slow output", cyc, 18);
        chk(tog[REF] > ref0, "R4", "pending slow pulse completed", tog[REF] - ref0, 1);
        snap(s);
        cpu_stop_n = 1'b0; tick(7);
        pci_stop_n = 1'b0; tick(7);
        cpu_stop_n = 1'b1; tick(7);
        pci_stop_n = 1'b1; tick(10);
        chk(!xtal_en && !vco_en, "R7", "stop inputs ignored in power-down", int'(xtal_en), 0);
        chk(moved(s) == 0, "R3", "no toggles while oscillators off", moved(s), 0);
        chk(clk_out == '0, "R7", "outputs stay low", int'(clk_out), 0);
    endtask

    task automatic t_wake_nolock();
        int s[N];
        pll_lock = 1'b0;
        snap(s);
        pd_n = 1'b1;
        tick(2);
        chk(!xtal_en, "R1", "enables still low after two edges", int'(xtal_en), 0);
        tick(1);
        chk(xtal_en && vco_en, "R1", "enables high after third edge", int'(xtal_en), 1);
        tick(SETTLE + 30);
        chk(moved(s) == 0, "R8", "no outputs without lock", moved(s), 0);
        pll_lock = 1'b1;
        tick(40);
        chk(moved(s) > 0 && tog[0] > s[0], "R8", "outputs after lock", moved(s), 1);
    endtask

    task automatic t_wake_settle();
        int s[N];
        int cyc;
        tick(10);
        pd_n = 1'b0;
        wait_off(cyc);
        chk(!xtal_en, "R3", "second power-down reached", int'(xtal_en), 0);
        snap(s);
        pd_n = 1'b1;
        tick(3);
        tick(SETTLE);
        chk(moved(s) == 0, "R8", "no toggles before settle expiry", moved(s), 0);
        tick(30);
        chk(tog[1] > s[1], "R8", "outputs after settle", tog[1] - s[1], 1);
    endtask

    task automatic t_abort();
        int s[N];
        int cyc;
        tick(10);
        pd_n = 1'b0;
        wait_off(cyc);
        snap(s);
        pd_n = 1'b1;
        tick(3);
        chk(xtal_en, "R9", "woke before abort", int'(xtal_en), 1);
        tick(10);
        pd_n = 1'b0;
        tick(3);
        chk(!xtal_en && !vco_en, "R9", "abort returns to off", int'(xtal_en), 0);
        chk(moved(s) == 0, "R9", "no pulse during aborted wake", moved(s), 0);
        pd_n = 1'b1;
        tick(SETTLE + 40);
        chk(tog[REF] >= s[REF] && tog[3] > s[3], "R9", "recovery after abort", tog[3] - s[3], 1);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin tog[i] = 0; runt[i] = 0; t_rise[i] = 0.0; end
        t_reset();
        t_glitch();
        t_enables();
        t_stops();
        t_powerdown();
        t_wake_nolock();
        t_glitch();
        t_wake_settle();
        t_abort();
        for (int i = 0; i < N; i++)
            chk(runt[i] == 0, "R2", "short pulses on output", runt[i], 0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #900us;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule